// File: doc/BRIEF.md
# Write Protect Command Gate

This block sits on a storage command path, between the command issuer and the media backend. It looks at every command as it is accepted. Most commands go straight on to the backend. A write-class command is also forwarded when the protect pin is not active. Once the active-low protect pin has been held asserted for longer than a qualification time, the block stops forwarding write-class commands. It answers each one itself, right away, with a completion. In the default policy that completion reports success, but nothing is written. In the alternative policy it carries a configurable, nonzero error code.

The pin reaches the block already debounced. The block still passes it through a synchronizer, then times how long it stays asserted. The pin state and the policy are captured at the moment a command is accepted, so later changes cannot alter the outcome of a pending command.

All three command-carrying interfaces are valid/ready: command in, forward out and completion out. A transfer happens on a rising edge where valid and ready are both high. The block holds one command at a time. While it waits on either output, it holds `cmd_ready` low. A held output keeps its valid high and its payload unchanged until the receiver takes it. The policy select is a plain level input.

Top module: `wp_cmd_gate`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `fwd_valid` and `cpl_valid` are 0.
- R2: A command whose opcode is not write-class is forwarded unchanged, whatever the protect pin does.
- R3: The write-class opcodes are 0x01 (write), 0x04 (write uncorrectable), 0x08 (write zeroes), 0x80 (format) and 0x84 (sanitize). When protection is not qualified, each of them is forwarded unchanged.
- R4: Protection qualifies only after `wp_n` has been low for more than QUAL_CYCLES clock cycles, plus a SYNC_STAGES synchronizer delay. A write accepted earlier than that is forwarded. A write accepted later is answered by a completion and is not forwarded.
- R5: Any return of `wp_n` to high clears qualification, and the time count starts again from zero.
- R6: With `err_mode` = 0, a blocked write completes with `cpl_status` = 0x00 (success) and echoes the opcode on `cpl_opcode`.
- R7: With `err_mode` = 1, a blocked write completes with `cpl_status` = ERR_CODE, which defaults to 0x82.
- R8: The outcome of an accepted command is presented on the cycle after acceptance. The outcome is `fwd_valid` for a forwarded command and `cpl_valid` for a blocked one, never both. While the completion is not taken, `cpl_valid`, `cpl_status` and `cpl_opcode` hold steady and `cmd_ready` stays 0.
- R9: While a forward is not taken, `fwd_valid` and `fwd_opcode` hold steady and `cmd_ready` stays 0. After the handshake, `cmd_ready` returns to 1 on the next cycle.
- R10: The pin qualification and `err_mode` are sampled at acceptance. Changes made while the command's output waits have no effect on that command's outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Debounced write-protect pin, active low |
| err_mode | input | 1 | Blocked-write policy: 0 = fake success, 1 = error |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_opcode | input | 8 | Command opcode |
| fwd_valid | output | 1 | Command offered to backend |
| fwd_ready | input | 1 | Backend takes the command |
| fwd_opcode | output | 8 | Forwarded opcode |
| cpl_valid | output | 1 | Local completion offered |
| cpl_ready | input | 1 | Completion taken |
| cpl_status | output | STS_W | Completion status code |
| cpl_opcode | output | 8 | Opcode of the completed command |

## Verification
A command is accepted on a rising edge. Its forward or completion becomes visible right after that edge, so the bench samples both outputs at the following falling edge and requires exactly one of them. Readiness returns one edge after the output handshake, and the bench checks `cmd_ready` at the falling edge after that. Protection becomes effective SYNC_STAGES + QUAL_CYCLES + 1 edges after `wp_n` falls. The bench never samples near that boundary: it issues writes a few cycles before it and a few cycles after it, and samples at falling edges only.

// File: rtl/wp_gate_pkg.sv
package wp_gate_pkg;
  typedef logic [7:0] opc_t;

  localparam opc_t OPC_WRITE      = 8'h01;
  localparam opc_t OPC_WRITE_UNC  = 8'h04;
  localparam opc_t OPC_WRITE_ZERO = 8'h08;
  localparam opc_t OPC_FORMAT     = 8'h80;
  localparam opc_t OPC_SANITIZE   = 8'h84;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_FWD  = 2'd1,
    GS_CPL  = 2'd2
  } gate_state_e;

  function automatic logic opc_is_write(input opc_t opc);
    case (opc)
      OPC_WRITE, OPC_WRITE_UNC, OPC_WRITE_ZERO,
      OPC_FORMAT, OPC_SANITIZE: opc_is_write = 1'b1;
      default:                  opc_is_write = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wp_pin_qualifier.sv
module wp_pin_qualifier #(
  parameter int QUAL_CYCLES = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic protect_qual
);
  localparam int CNT_MAX = QUAL_CYCLES + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_on;
  logic [CNT_W-1:0]       hold_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ~wp_n;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~wp_n};
    end
  endgenerate

  assign pin_on = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           hold_cnt <= '0;
    else if (!pin_on)                     hold_cnt <= '0;
    else if (hold_cnt != CNT_W'(CNT_MAX)) hold_cnt <= hold_cnt + 1'b1;
  end

  assign protect_qual = (hold_cnt == CNT_W'(CNT_MAX));

  // R5: a released pin removes qualification on the next cycle
  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_on |=> !protect_qual);
  // R4: qualification can only rise after the pin was already on
  assert_qual_needs_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_qual) |-> $past(pin_on));
endmodule

// File: rtl/wp_cmd_fsm.sv
module wp_cmd_fsm
  import wp_gate_pkg::*;
#(
  parameter int                STS_W    = 8,
  parameter logic [STS_W-1:0]  ERR_CODE = 8'h82
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  opc_t             cmd_opcode,
  input  logic             is_write,
  input  logic             protect_qual,
  input  logic             err_mode,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output opc_t             fwd_opcode,
  output logic             cpl_valid,
  input  logic             cpl_ready,
  output logic [STS_W-1:0] cpl_status,
  output opc_t             cpl_opcode
);
  gate_state_e      state_q;
  opc_t             opc_q;
  logic [STS_W-1:0] sts_q;
  logic             accept;
  logic             block_now;

  assign accept    = cmd_valid && cmd_ready;
  assign block_now = is_write && protect_qual;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      opc_q   <= '0;
      sts_q   <= '0;
    end else begin
      case (state_q)
        GS_IDLE: if (accept) begin
          opc_q   <= cmd_opcode;
          sts_q   <= err_mode ? ERR_CODE : '0;
          state_q <= block_now ? GS_CPL : GS_FWD;
        end
        GS_FWD:  if (fwd_ready) state_q <= GS_IDLE;
        GS_CPL:  if (cpl_ready) state_q <= GS_IDLE;
        default: state_q <= GS_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == GS_IDLE);
  assign fwd_valid  = (state_q == GS_FWD);
  assign cpl_valid  = (state_q == GS_CPL);
  assign fwd_opcode = opc_q;
  assign cpl_opcode = opc_q;
  assign cpl_status = sts_q;

  // R8: a blocked accept yields a completion on the next cycle
  assert_block_to_cpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && block_now) |=> (cpl_valid && !fwd_valid));
  // R2/R3: an unblocked accept yields a forward on the next cycle
  assert_pass_to_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !block_now) |=> (fwd_valid && !cpl_valid));
  // R9: a stalled forward holds its payload
  assert_fwd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_opcode)));
  // R8: a stalled completion holds its payload
  assert_cpl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_status) && $stable(cpl_opcode)));
  // R6: dummy-mode acceptance gives a zero status
  assert_dummy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && block_now && !err_mode) |=> (cpl_status == '0));
endmodule

// File: rtl/wp_cmd_gate.sv
module wp_cmd_gate
  import wp_gate_pkg::*;
#(
  parameter int               QUAL_CYCLES = 1000000,
  parameter int               SYNC_STAGES = 2,
  parameter int               STS_W       = 8,
  parameter logic [STS_W-1:0] ERR_CODE    = 8'h82
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             err_mode,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_opcode,
  output logic             fwd_valid,
  input  logic             fwd_ready,
  output logic [7:0]       fwd_opcode,
  output logic             cpl_valid,
  input  logic             cpl_ready,
  output logic [STS_W-1:0] cpl_status,
  output logic [7:0]       cpl_opcode
);
  logic protect_qual;
  logic is_write;

  assign is_write = opc_is_write(cmd_opcode);

  wp_pin_qualifier #(
    .QUAL_CYCLES (QUAL_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_qual (
    .clk          (clk),
    .rst_n        (rst_n),
    .wp_n         (wp_n),
    .protect_qual (protect_qual)
  );

  wp_cmd_fsm #(
    .STS_W    (STS_W),
    .ERR_CODE (ERR_CODE)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_opcode   (cmd_opcode),
    .is_write     (is_write),
    .protect_qual (protect_qual),
    .err_mode     (err_mode),
    .fwd_valid    (fwd_valid),
    .fwd_ready    (fwd_ready),
    .fwd_opcode   (fwd_opcode),
    .cpl_valid    (cpl_valid),
    .cpl_ready    (cpl_ready),
    .cpl_status   (cpl_status),
    .cpl_opcode   (cpl_opcode)
  );

  // R2: a non-write command never produces a local completion
  assert_nonwrite_no_cpl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !opc_is_write(cmd_opcode)) |=> !cpl_valid);
  // R8: outputs are mutually exclusive and block intake
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && cpl_valid) && !(cmd_ready && (fwd_valid || cpl_valid)));
endmodule

// File: tb/wp_cmd_gate_bench.sv
module wp_cmd_gate_bench;
  localparam int QUAL = 20;
  localparam int SYNC = 2;
  localparam logic [7:0] ERRC = 8'h82;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_n = 1'b1;
  logic       err_mode = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_opcode = 8'h00;
  logic       fwd_ready = 1'b0;
  logic       cpl_ready = 1'b0;
  logic       cmd_ready, fwd_valid, cpl_valid;
  logic [7:0] fwd_opcode, cpl_status, cpl_opcode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wp_cmd_gate #(.QUAL_CYCLES(QUAL), .SYNC_STAGES(SYNC), .STS_W(8), .ERR_CODE(ERRC)) u_wp_cmd_gate (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .err_mode(err_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_opcode(fwd_opcode),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
    .cpl_opcode(cpl_opcode));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Issue one command at a falling edge; hold the outcome 'hold' cycles, then take it.
  // Expects a forward (exp_blk=0) or a completion with status exp_sts (exp_blk=1).
  task automatic run_cmd(input logic [7:0] opc, input bit exp_blk, input logic [7:0] exp_sts,
                         input int hold, input string req);
    check(cmd_ready == 1'b1, req, cmd_ready, 1);
    cmd_valid  = 1'b1;
    cmd_opcode = opc;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(fwd_valid == !exp_blk, req, fwd_valid, !exp_blk);
    check(cpl_valid == exp_blk, req, cpl_valid, exp_blk);
    if (exp_blk) begin
      check(cpl_status == exp_sts, req, cpl_status, exp_sts);
      check(cpl_opcode == opc, req, cpl_opcode, opc);
    end else begin
      check(fwd_opcode == opc, req, fwd_opcode, opc);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(cmd_ready == 1'b0, req, cmd_ready, 0);
      if (exp_blk) begin
        check(cpl_valid && cpl_status == exp_sts && cpl_opcode == opc, req, cpl_status, exp_sts);
      end else begin
        check(fwd_valid && fwd_opcode == opc, req, fwd_opcode, opc);
      end
    end
    fwd_ready = 1'b1;
    cpl_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    cpl_ready = 1'b0;
    check(cmd_ready && !fwd_valid && !cpl_valid, req, cmd_ready, 1);
  endtask

  task automatic pin_low(input int cycles);
    wp_n = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic pin_high();
    wp_n = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic t_reset_r1();
    check(cmd_ready == 1'b1, "R1", cmd_ready, 1);
    check(fwd_valid == 1'b0, "R1", fwd_valid, 0);
    check(cpl_valid == 1'b0, "R1", cpl_valid, 0);
  endtask

  task automatic t_open_writes_r3();
    logic [7:0] w [5] = '{8'h01, 8'h04, 8'h08, 8'h80, 8'h84};
    foreach (w[i]) run_cmd(w[i], 0, 8'h00, 0, "R3");
  endtask

  task automatic t_nonwrite_r2();
    logic [7:0] nw [4] = '{8'h02, 8'h00, 8'h05, 8'h81};
    foreach (nw[i]) run_cmd(nw[i], 0, 8'h00, 0, "R2");
    pin_low(QUAL + SYNC + 6);
    foreach (nw[i]) run_cmd(nw[i], 0, 8'h00, 0, "R2");
    pin_high();
  endtask

  task automatic t_qual_r4();
    pin_low(QUAL - 3);
    run_cmd(8'h01, 0, 8'h00, 0, "R4");
    repeat (SYNC + 8) @(negedge clk);
    run_cmd(8'h01, 1, 8'h00, 0, "R4");
    pin_high();
    run_cmd(8'h01, 0, 8'h00, 0, "R4");
  endtask

  task automatic t_restart_r5();
    pin_low(QUAL + SYNC + 6);
    wp_n = 1'b1;
    repeat (3) @(negedge clk);
    pin_low(SYNC + 2);
    run_cmd(8'h08, 0, 8'h00, 0, "R5");
    repeat (QUAL) @(negedge clk);
    run_cmd(8'h08, 1, 8'h00, 0, "R5");
    pin_high();
  endtask

  task automatic t_dummy_r6();
    logic [7:0] w [5] = '{8'h84, 8'h80, 8'h08, 8'h04, 8'h01};
    err_mode = 1'b0;
    pin_low(QUAL + SYNC + 6);
    foreach (w[i]) run_cmd(w[i], 1, 8'h00, 0, "R6");
    pin_high();
  endtask

  task automatic t_error_r7();
    err_mode = 1'b1;
    pin_low(QUAL + SYNC + 6);
    run_cmd(8'h01, 1, ERRC, 0, "R7");
    run_cmd(8'h80, 1, ERRC, 0, "R7");
    run_cmd(8'h02, 0, 8'h00, 0, "R7");
    pin_high();
    err_mode = 1'b0;
  endtask

  task automatic t_cpl_stall_r8();
    err_mode = 1'b1;
    pin_low(QUAL + SYNC + 6);
    run_cmd(8'h04, 1, ERRC, 4, "R8");
    pin_high();
    err_mode = 1'b0;
  endtask

  task automatic t_fwd_stall_r9();
    run_cmd(8'h02, 0, 8'h00, 5, "R9");
    run_cmd(8'h84, 0, 8'h00, 3, "R9");
  endtask

  task automatic t_sample_r10();
    err_mode = 1'b0;
    pin_low(QUAL + SYNC + 6);
    check(cmd_ready == 1'b1, "R10", cmd_ready, 1);
    cmd_valid  = 1'b1;
    cmd_opcode = 8'h01;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    err_mode  = 1'b1;
    wp_n      = 1'b1;
    repeat (5) @(negedge clk);
    check(cpl_valid == 1'b1, "R10", cpl_valid, 1);
    check(cpl_status == 8'h00, "R10", cpl_status, 0);
    check(fwd_valid == 1'b0, "R10", fwd_valid, 0);
    cpl_ready = 1'b1;
    @(negedge clk);
    cpl_ready = 1'b0;
    run_cmd(8'h01, 0, 8'h00, 0, "R10");
    err_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_open_writes_r3();
    t_nonwrite_r2();
    t_qual_r4();
    t_restart_r5();
    t_dummy_r6();
    t_error_r7();
    t_cpl_stall_r8();
    t_fwd_stall_r9();
    t_sample_r10();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule